// File: doc/BRIEF.md
# Owner-Tagged Frame Search Unit

This unit translates a virtual address issued by a process into a physical address. It uses a reverse mapping table that has exactly one slot per physical frame. Each slot records which virtual page currently sits in that frame and which process owns it. The slot's own position is the frame number, so the table stores no frame numbers at all.

A lookup presents a process ID and a 32-bit virtual address. The unit then walks the slots one per clock, starting at slot 0. It stops at the first slot that is marked valid and whose stored page and owner both equal the request. The physical address is that slot's index followed by the untouched page offset. If every slot fails to match, the unit reports a miss, which system software treats as a page fault.

Software fills the table through a simple write port. That port takes effect only while no walk is in progress.

Top module: `owner_page_search`

## Requirements
- R1: After reset `busy` and `doneValid` are 0, and every slot is invalid, so any lookup issued before a write reports a miss.
- R2: On a hit, `donePaddr[15:12]` holds the index of the matching slot and `donePaddr[11:0]` equals `reqVaddr[11:0]` of the request.
- R3: Slots are compared one per cycle in ascending order from index 0, and the lowest matching index wins. A request accepted at a clock edge produces `doneValid` at the (i+1)-th following edge when slot i matches.
- R4: When no slot matches, `doneValid` rises at the 16th edge after acceptance, with `doneHit`=0 and `donePaddr`=0.
- R5: A slot matches only if both its stored process ID equals `reqPid` and its stored page equals `reqVaddr[31:12]`. A match on only one of the two is not enough.
- R6: A slot written with `writeValid`=0 never matches, even when its page and owner fields agree with the request.
- R7: A write (`writeEn`=1) is applied to slot `writeIdx` at the clock edge only if `busy` is 0 at that edge. Writes made while `busy` is 1 are dropped.
- R8: `reqValid` is accepted only while `busy` is 0. A request raised during a walk neither changes the result in progress nor starts a later walk.
- R9: `busy` is 1 from the edge after acceptance until the edge that raises `doneValid`. `doneValid` is a single-cycle pulse, and `busy` is 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| writeEn | input | 1 | Table write strobe |
| writeIdx | input | 4 | Slot (frame) index to write |
| writeValid | input | 1 | Valid flag stored in the slot |
| writePid | input | 4 | Owner process ID stored in the slot |
| writeVpn | input | 20 | Virtual page number stored in the slot |
| reqValid | input | 1 | Lookup request strobe |
| reqPid | input | 4 | Requesting process ID |
| reqVaddr | input | 32 | Virtual address: page in [31:12], offset in [11:0] |
| busy | output | 1 | A walk is in progress |
| doneValid | output | 1 | One-cycle result strobe |
| doneHit | output | 1 | 1 when a slot matched |
| donePaddr | output | 16 | Frame index concatenated with the offset; 0 on a miss |

## Verification
The hardest cases to reach from the ports are the ones that depend on activity during a walk.

- **Dropped write (R7):** the bench starts a 16-cycle miss walk and issues a table write a few cycles into it. A later lookup for the written pair must still miss.
- **Ignored request (R8):** a second request is held for several cycles mid-walk, and no extra result may follow.
- **Ordering and validity (R3, R6):** these are reached by preloading duplicate page/owner pairs at two indices. An invalid twin is placed ahead of a valid one. The bench then checks both the returned index and the exact latency.

// File: rtl/owner_page_search_pkg.sv
package owner_page_search_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_t;

  typedef struct packed {
    logic writeAllow;
    logic captureReq;
    logic stepIdx;
    logic finishHit;
    logic finishMiss;
  } scanStrobe_t;

endpackage

// File: rtl/owner_page_search_ctrl.sv
module owner_page_search_ctrl
  import owner_page_search_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        matchNow,
  input  logic        atLastIdx,
  output scanStrobe_t strb,
  output logic        busy
);

  scanState_t state, stateNext;

  always_comb begin
    strb = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        strb.writeAllow = 1'b1;
        if (reqValid) begin
          strb.captureReq = 1'b1;
          stateNext = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (matchNow) begin
          strb.finishHit = 1'b1;
          stateNext = ST_IDLE;
        end else if (atLastIdx) begin
          strb.finishMiss = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strb.stepIdx = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_SCAN);

endmodule

// File: rtl/owner_page_search_dp.sv
module owner_page_search_dp
  import owner_page_search_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 4,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       strb,
  input  logic              writeEn,
  input  logic [IDX_W-1:0]  writeIdx,
  input  logic              writeValid,
  input  logic [PID_W-1:0]  writePid,
  input  logic [VPN_W-1:0]  writeVpn,
  input  logic [PID_W-1:0]  reqPid,
  input  logic [VPN_W-1:0]  reqVpn,
  input  logic [OFF_W-1:0]  reqOff,
  output logic              matchNow,
  output logic              atLastIdx,
  output logic              doneValid,
  output logic              doneHit,
  output logic [PA_W-1:0]   donePaddr
);

  logic [ENTRIES-1:0] entryValid;
  logic [PID_W-1:0]   entryPid [ENTRIES];
  logic [VPN_W-1:0]   entryVpn [ENTRIES];

  logic [PID_W-1:0]   keyPid;
  logic [VPN_W-1:0]   keyVpn;
  logic [OFF_W-1:0]   keyOff;
  logic [IDX_W-1:0]   scanIdx;
  logic [ENTRIES-1:0] matchVec;

  // Table storage: one slot per frame, loaded only while idle.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryValid[g] <= 1'b0;
        entryPid[g]   <= '0;
        entryVpn[g]   <= '0;
      end else if (writeEn && strb.writeAllow && (writeIdx == IDX_W'(g))) begin
        entryValid[g] <= writeValid;
        entryPid[g]   <= writePid;
        entryVpn[g]   <= writeVpn;
      end
    end

    assign matchVec[g] = entryValid[g] && (entryPid[g] == keyPid) && (entryVpn[g] == keyVpn);
  end

  // Request key and scan pointer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyPid  <= '0;
      keyVpn  <= '0;
      keyOff  <= '0;
      scanIdx <= '0;
    end else if (strb.captureReq) begin
      keyPid  <= reqPid;
      keyVpn  <= reqVpn;
      keyOff  <= reqOff;
      scanIdx <= '0;
    end else if (strb.stepIdx) begin
      scanIdx <= scanIdx + 1'b1;
    end
  end

  assign matchNow  = matchVec[scanIdx];
  assign atLastIdx = (scanIdx == IDX_W'(ENTRIES - 1));

  // Result registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneHit   <= 1'b0;
      donePaddr <= '0;
    end else begin
      doneValid <= strb.finishHit | strb.finishMiss;
      if (strb.finishHit) begin
        doneHit   <= 1'b1;
        donePaddr <= {scanIdx, keyOff};
      end else if (strb.finishMiss) begin
        doneHit   <= 1'b0;
        donePaddr <= '0;
      end
    end
  end

endmodule

// File: rtl/owner_page_search.sv
module owner_page_search
  import owner_page_search_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 4,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             writeEn,
  input  logic [IDX_W-1:0] writeIdx,
  input  logic             writeValid,
  input  logic [PID_W-1:0] writePid,
  input  logic [VPN_W-1:0] writeVpn,
  input  logic             reqValid,
  input  logic [PID_W-1:0] reqPid,
  input  logic [VA_W-1:0]  reqVaddr,
  output logic             busy,
  output logic             doneValid,
  output logic             doneHit,
  output logic [PA_W-1:0]  donePaddr
);

  scanStrobe_t strb;
  logic        matchNow;
  logic        atLastIdx;

  owner_page_search_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .matchNow  (matchNow),
    .atLastIdx (atLastIdx),
    .strb      (strb),
    .busy      (busy)
  );

  owner_page_search_dp #(
    .ENTRIES (ENTRIES),
    .PID_W   (PID_W),
    .VPN_W   (VPN_W),
    .OFF_W   (OFF_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .writeEn    (writeEn),
    .writeIdx   (writeIdx),
    .writeValid (writeValid),
    .writePid   (writePid),
    .writeVpn   (writeVpn),
    .reqPid     (reqPid),
    .reqVpn     (reqVaddr[VA_W-1:OFF_W]),
    .reqOff     (reqVaddr[OFF_W-1:0]),
    .matchNow   (matchNow),
    .atLastIdx  (atLastIdx),
    .doneValid  (doneValid),
    .doneHit    (doneHit),
    .donePaddr  (donePaddr)
  );

endmodule

// File: rtl/owner_page_search_chk.sv
module owner_page_search_chk #(
  parameter int ENTRIES = 16,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 16,
  parameter int VA_W    = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVaddr,
  input logic            busy,
  input logic            doneValid,
  input logic            doneHit,
  input logic [PA_W-1:0] donePaddr
);

  localparam int CNT_W = $clog2(ENTRIES) + 1;

  logic [OFF_W-1:0] shadowOff;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowOff <= '0;
      busyCnt   <= '0;
    end else begin
      if (reqValid && !busy) shadowOff <= reqVaddr[OFF_W-1:0];
      busyCnt <= busy ? busyCnt + 1'b1 : '0;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r9_idle_on_done: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !busy);

  a_r9_busy_ends_with_result: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneValid);

  a_r8_accept_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  a_r4_miss_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneHit) |-> (donePaddr == '0));

  a_r4_walk_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < CNT_W'(ENTRIES)));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneHit) |-> (donePaddr[OFF_W-1:0] == shadowOff));

endmodule

bind owner_page_search owner_page_search_chk #(
  .ENTRIES (ENTRIES),
  .OFF_W   (OFF_W),
  .PA_W    (PA_W),
  .VA_W    (VA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqVaddr  (reqVaddr),
  .busy      (busy),
  .doneValid (doneValid),
  .doneHit   (doneHit),
  .donePaddr (donePaddr)
);

// File: tb/owner_page_search_bench.sv
`timescale 1ns/1ps
module owner_page_search_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        writeEn = 1'b0;
  logic [3:0]  writeIdx = '0;
  logic        writeValid = 1'b0;
  logic [3:0]  writePid = '0;
  logic [19:0] writeVpn = '0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqPid = '0;
  logic [31:0] reqVaddr = '0;
  logic        busy, doneValid, doneHit;
  logic [15:0] donePaddr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  owner_page_search u_owner_page_search (
    .clk(clk), .rstN(rstN),
    .writeEn(writeEn), .writeIdx(writeIdx), .writeValid(writeValid),
    .writePid(writePid), .writeVpn(writeVpn),
    .reqValid(reqValid), .reqPid(reqPid), .reqVaddr(reqVaddr),
    .busy(busy), .doneValid(doneValid), .doneHit(doneHit), .donePaddr(donePaddr)
  );

  // {pid, vaddr, expHit, expPaddr, expLatency}
  localparam int NVEC = 9;
  localparam logic [57:0] VECS [NVEC] = '{
    {4'd3,  32'h0001_0123, 1'b1, 16'h0123, 5'd1},   // R2 slot 0
    {4'd5,  32'h0001_0FFF, 1'b1, 16'h1FFF, 5'd2},   // R5 same page, other owner
    {4'd3,  32'hABCD_E000, 1'b1, 16'h2000, 5'd3},   // R2
    {4'd7,  32'h1234_5055, 1'b1, 16'h5055, 5'd6},   // R6 invalid twin at 3
    {4'd9,  32'h0F0F_0A5A, 1'b1, 16'h6A5A, 5'd7},   // R3 lowest of 6 and 9
    {4'd15, 32'hFFFF_F800, 1'b1, 16'hF800, 5'd16},  // R3 last slot
    {4'd4,  32'h0001_0123, 1'b0, 16'h0000, 5'd16},  // R5 page only
    {4'd3,  32'h0001_1123, 1'b0, 16'h0000, 5'd16},  // R5 owner only
    {4'd0,  32'h0000_0000, 1'b0, 16'h0000, 5'd16}   // R4 empty slots
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [3:0] idx, input logic v,
                            input logic [3:0] pid, input logic [19:0] vpn);
    @(negedge clk);
    writeEn = 1'b1; writeIdx = idx; writeValid = v; writePid = pid; writeVpn = vpn;
    @(negedge clk);
    writeEn = 1'b0;
  endtask

  task automatic startReq(input logic [3:0] pid, input logic [31:0] va);
    @(negedge clk);
    reqValid = 1'b1; reqPid = pid; reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 busy after accept", {31'd0, busy}, 32'd1);
  endtask

  task automatic waitDone(output logic hit, output logic [15:0] pa, output int lat);
    lat = 0;
    while (!doneValid && lat < 40) begin
      @(negedge clk);
      lat++;
      if (!doneValid && busy !== 1'b1) begin
        checks++; failures++;
        $display("FAIL R9 busy dropped before result actual=%b expected=1", busy);
      end
    end
    hit = doneHit; pa = donePaddr;
    check("R9 idle with result", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R9 single-cycle result", {31'd0, doneValid}, 32'd0);
  endtask

  initial begin : main
    logic h; logic [15:0] pa; int lat;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy}, 32'd0);
    check("R1 doneValid in reset", {31'd0, doneValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);

    startReq(4'd0, 32'h0000_0000);
    waitDone(h, pa, lat);
    check("R1 empty table misses", {31'd0, h}, 32'd0);
    check("R4 miss latency", lat, 16);

    writeEntry(4'd0,  1'b1, 4'd3,  20'h00010);
    writeEntry(4'd1,  1'b1, 4'd5,  20'h00010);
    writeEntry(4'd2,  1'b1, 4'd3,  20'hABCDE);
    writeEntry(4'd3,  1'b0, 4'd7,  20'h12345);
    writeEntry(4'd5,  1'b1, 4'd7,  20'h12345);
    writeEntry(4'd6,  1'b1, 4'd9,  20'h0F0F0);
    writeEntry(4'd9,  1'b1, 4'd9,  20'h0F0F0);
    writeEntry(4'd15, 1'b1, 4'd15, 20'hFFFFF);

    for (int i = 0; i < NVEC; i++) begin
      startReq(VECS[i][57:54], VECS[i][53:22]);
      waitDone(h, pa, lat);
      check($sformatf("R2/R3/R4/R5/R6 vec%0d hit", i), {31'd0, h}, {31'd0, VECS[i][21]});
      check($sformatf("R2/R4 vec%0d paddr", i), {16'd0, pa}, {16'd0, VECS[i][20:5]});
      check($sformatf("R3/R4 vec%0d latency", i), lat, {27'd0, VECS[i][4:0]});
    end

    // R7: write during a walk is dropped
    startReq(4'd0, 32'h0000_0000);
    fork
      waitDone(h, pa, lat);
      begin
        repeat (2) @(negedge clk);
        writeEn = 1'b1; writeIdx = 4'd4; writeValid = 1'b1;
        writePid = 4'd2; writeVpn = 20'h22222;
        @(negedge clk);
        writeEn = 1'b0;
      end
    join
    startReq(4'd2, 32'h2222_2010);
    waitDone(h, pa, lat);
    check("R7 busy write dropped", {31'd0, h}, 32'd0);
    writeEntry(4'd4, 1'b1, 4'd2, 20'h22222);
    startReq(4'd2, 32'h2222_2010);
    waitDone(h, pa, lat);
    check("R7 idle write applied hit", {31'd0, h}, 32'd1);
    check("R7 idle write paddr", {16'd0, pa}, 32'h0000_4010);
    check("R3 slot4 latency", lat, 5);

    // R8: request during a walk is ignored
    startReq(4'd0, 32'h0000_0000);
    fork
      waitDone(h, pa, lat);
      begin
        repeat (2) @(negedge clk);
        reqValid = 1'b1; reqPid = 4'd3; reqVaddr = 32'h0001_0123;
        repeat (3) @(negedge clk);
        reqValid = 1'b0;
      end
    join
    check("R8 original miss kept", {31'd0, h}, 32'd0);
    check("R8 original latency", lat, 16);
    begin
      int extra = 0;
      repeat (20) begin
        @(negedge clk);
        if (doneValid || busy) extra++;
      end
      check("R8 no extra walk", extra, 0);
    end

    // R6: invalidating slot 0 removes its mapping
    writeEntry(4'd0, 1'b0, 4'd3, 20'h00010);
    startReq(4'd3, 32'h0001_0123);
    waitDone(h, pa, lat);
    check("R6 invalidated slot misses", {31'd0, h}, 32'd0);
    check("R4 invalidated paddr zero", {16'd0, pa}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule